// File: doc/BRIEF.md
# Four-Phase Pipelined Instruction Sequencer

This block turns one fast input clock into a four-phase instruction cycle. A two-bit phase counter walks through four phase strobes, one per input clock. Each full pass through the four phases is one instruction cycle. On this time base the block runs a two-stage pipeline. While one instruction executes, the next one is being fetched. A sequential program therefore completes one instruction per instruction cycle.

In every cycle the block does the following. It tells the program-counter logic to advance in phase one. It captures the word on the fetch bus in phase four, into a prefetch holding register. On the edge that ends the next phase one, it moves that word into the instruction register, where it stays for decode and execute. It emits a data-memory read strobe in phase two and a destination write strobe in phase four.

When the executing instruction redirects the program counter, the surrounding logic raises a change request in phase four. The block then spends the whole next instruction cycle as a flush cycle. The already-fetched word is replaced by a no-op, and that cycle issues neither a read nor a write. The decoder, the ALU and the memories sit outside this block.

Top module: `quad_phase_seq`

## Requirements
- R1: Exactly one bit of `phase_oh` is high in every clock after reset. Bit 0 is phase one and bit 3 is phase four. The phases advance one per clock in the order 0,1,2,3,0.
- R2: While `rst_n` is low at a rising edge, the block returns to phase one (`phase_oh`=4'b0001). It clears `flush`, sets `ir_word` to the no-op word (all zeros by default), and keeps `dst_wr` low.
- R3: `pc_adv` and `ir_load` are high exactly in phase one.
- R4: `fetch_latch` is high exactly in phase four. The `fetch_word` value present in phase four appears on `ir_word` from phase two of the next instruction cycle, unless that cycle is flushed.
- R5: In an instruction cycle that is not flushed, `opnd_rd` is high only in phase two and `dst_wr` is high only in phase four.
- R6: `dst_wr` stays low in the first instruction cycle after reset.
- R7: `pc_change_req` is sampled only in phase four. If it is high there, `flush` is high for all four phases of the next instruction cycle. If it is high in any other phase, it has no effect.
- R8: In a flushed cycle, `ir_word` holds the no-op word from phase two to phase four, and `opnd_rd` and `dst_wr` stay low.
- R9: A change request made during a flushed cycle is ignored, so one redirect produces exactly one flushed cycle.
- R10: With no change requests, each instruction cycle puts a new fetched word on `ir_word`. The pipeline sustains one instruction per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, one phase per period |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_word | input | WORD_W | Word returned by program memory |
| pc_change_req | input | 1 | Executing instruction redirects the PC (sampled in phase four) |
| phase_oh | output | 4 | One-hot phase strobes, bit 0 = phase one |
| pc_adv | output | 1 | Advance the program counter |
| fetch_latch | output | 1 | Fetch word is being captured |
| ir_load | output | 1 | Instruction register is being loaded |
| opnd_rd | output | 1 | Data-memory operand read strobe |
| dst_wr | output | 1 | Destination write strobe |
| flush | output | 1 | Current instruction cycle is a flushed no-op |
| ir_word | output | WORD_W | Instruction register contents |

## Verification
The hardest cases to reach are the redirect corner cases. One is a change request that arrives while a flush is already under way. The other is a request held high in every phase except phase four. The bench drives `pc_change_req` per phase through a four-bit mask. It then scripts cycles that raise the request in the flushed cycle, in non-sampling phases only, and in two redirects separated by exactly one normal cycle. Each script is compared clock by clock against a model of the prefetch word, the instruction register and the flush state.

// File: rtl/qseq_pkg.sv
// Package: shared phase encoding for the four-phase sequencer.
// Assumes the instruction cycle always has exactly four phases.
package qseq_pkg;
    localparam int NUM_PHASES = 4;
    typedef enum logic [1:0] {
        PH_ONE   = 2'd0,
        PH_TWO   = 2'd1,
        PH_THREE = 2'd2,
        PH_FOUR  = 2'd3
    } phase_e;
endpackage

// File: rtl/qseq_phase_gen.sv
// Module: qseq_phase_gen
// Divides the input clock into NUM_PH one-hot phase strobes, one per clock.
// Assumes a synchronous active-low reset that returns to the first phase.
module qseq_phase_gen #(
    parameter int NUM_PH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [NUM_PH-1:0] phase_oh
);
    localparam int PH_W = (NUM_PH > 1) ? $clog2(NUM_PH) : 1;
    localparam logic [PH_W-1:0] LAST_PH = PH_W'(NUM_PH - 1);

    logic [PH_W-1:0] ph_cnt;

    // Step the phase counter, wrapping after the last phase.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ph_cnt <= '0;
        else if (ph_cnt == LAST_PH)
            ph_cnt <= '0;
        else
            ph_cnt <= ph_cnt + 1'b1;
    end

    // Decode the counter into one strobe per phase.
    generate
        for (genvar g = 0; g < NUM_PH; g++) begin : g_dec
            assign phase_oh[g] = (ph_cnt == PH_W'(g));
        end
    endgenerate

    // R1
    one_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(phase_oh) == 1);

    // R1
    phase_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase_oh[NUM_PH-1] |=> phase_oh[0]);
endmodule

// File: rtl/qseq_fetch_stage.sv
// Module: qseq_fetch_stage
// Prefetch holding register: captures the program-memory word when latch_en
// (phase four) is high. Assumes fetch_word is stable during that phase.
module qseq_fetch_stage #(
    parameter int              WORD_W   = 16,
    parameter logic [WORD_W-1:0] NOP_WORD = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              latch_en,
    input  logic [WORD_W-1:0] fetch_word,
    output logic [WORD_W-1:0] prefetch_word
);
    // Hold the fetched word until the next latch strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prefetch_word <= NOP_WORD;
        else if (latch_en)
            prefetch_word <= fetch_word;
    end

    // R4
    prefetch_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        latch_en |=> prefetch_word == $past(fetch_word));
endmodule

// File: rtl/qseq_exec_stage.sv
// Module: qseq_exec_stage
// Instruction register, flush tracking and data-memory strobes.
// Assumes phase strobes are one-hot; pc_change_req is meaningful in phase four.
module qseq_exec_stage #(
    parameter int              WORD_W   = 16,
    parameter logic [WORD_W-1:0] NOP_WORD = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              q1,
    input  logic              q2,
    input  logic              q4,
    input  logic [WORD_W-1:0] prefetch_word,
    input  logic              pc_change_req,
    output logic [WORD_W-1:0] ir_word,
    output logic              flush,
    output logic              opnd_rd,
    output logic              dst_wr
);
    logic flush_q;
    logic first_q;

    // Decide at the phase-four edge whether the next cycle is flushed.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flush_q <= 1'b0;
        else if (q4)
            flush_q <= pc_change_req && !flush_q;
    end

    // Mark the first instruction cycle after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            first_q <= 1'b1;
        else if (q4)
            first_q <= 1'b0;
    end

    // Load the instruction register at the end of phase one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ir_word <= NOP_WORD;
        else if (q1)
            ir_word <= flush_q ? NOP_WORD : prefetch_word;
    end

    // Drive the data-memory strobes for non-flushed cycles.
    always_comb begin
        opnd_rd = q2 && !flush_q;
        dst_wr  = q4 && !flush_q && !first_q;
    end

    assign flush = flush_q;

    // R7
    flush_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flush_q) |-> $past(q4) && $past(pc_change_req));

    // R9
    single_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_q && q4) |=> !flush_q);

    // R8
    flush_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_q && !q1) |-> (ir_word == NOP_WORD) && !opnd_rd && !dst_wr);

    // R6
    first_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        first_q |-> !dst_wr);
endmodule

// File: rtl/quad_phase_seq.sv
// Module: quad_phase_seq
// Four-phase pipelined fetch/execute sequencer. Phase one advances the PC
// and loads the IR, phase four latches the fetched word. A PC change sampled
// in phase four flushes the following cycle. Assumes a synchronous
// active-low reset.
module quad_phase_seq
    import qseq_pkg::*;
#(
    parameter int              WORD_W   = 16,
    parameter logic [WORD_W-1:0] NOP_WORD = '0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [WORD_W-1:0]     fetch_word,
    input  logic                  pc_change_req,
    output logic [NUM_PHASES-1:0] phase_oh,
    output logic                  pc_adv,
    output logic                  fetch_latch,
    output logic                  ir_load,
    output logic                  opnd_rd,
    output logic                  dst_wr,
    output logic                  flush,
    output logic [WORD_W-1:0]     ir_word
);
    logic [WORD_W-1:0] prefetch_word;

    qseq_phase_gen #(.NUM_PH(NUM_PHASES)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase_oh (phase_oh)
    );

    // Map phase strobes onto the pipeline control outputs.
    always_comb begin
        pc_adv      = phase_oh[PH_ONE];
        ir_load     = phase_oh[PH_ONE];
        fetch_latch = phase_oh[PH_FOUR];
    end

    qseq_fetch_stage #(.WORD_W(WORD_W), .NOP_WORD(NOP_WORD)) u_fetch (
        .clk           (clk),
        .rst_n         (rst_n),
        .latch_en      (fetch_latch),
        .fetch_word    (fetch_word),
        .prefetch_word (prefetch_word)
    );

    qseq_exec_stage #(.WORD_W(WORD_W), .NOP_WORD(NOP_WORD)) u_exec (
        .clk           (clk),
        .rst_n         (rst_n),
        .q1            (phase_oh[PH_ONE]),
        .q2            (phase_oh[PH_TWO]),
        .q4            (phase_oh[PH_FOUR]),
        .prefetch_word (prefetch_word),
        .pc_change_req (pc_change_req),
        .ir_word       (ir_word),
        .flush         (flush),
        .opnd_rd       (opnd_rd),
        .dst_wr        (dst_wr)
    );

    // R5
    wr_in_four_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dst_wr |=> phase_oh[PH_ONE] && !opnd_rd);

    // R5
    rd_then_nowr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        opnd_rd |=> phase_oh[PH_THREE] && !dst_wr);
endmodule

// File: tb/quad_phase_seq_tb_top.sv
// Scoreboard bench: the driver pushes expected per-clock outputs, the
// monitor pops and compares them at each falling edge.
module quad_phase_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;
    localparam logic [W-1:0] NOP = '0;

    typedef struct {
        logic [3:0]   ph;
        logic         adv;
        logic         lat;
        logic         rd;
        logic         wr;
        logic         fl;
        logic [W-1:0] ir;
        string        rd_tag;
        string        wr_tag;
        string        fl_tag;
        string        ir_tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] fetch_word = '0;
    logic         pc_change_req = 1'b0;
    logic [3:0]   phase_oh;
    logic         pc_adv, fetch_latch, ir_load, opnd_rd, dst_wr, flush;
    logic [W-1:0] ir_word;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    bit   mon_on = 1'b0;

    // model state
    logic [W-1:0] m_pre = '0;
    logic [W-1:0] m_ir = '0;
    bit           m_flush = 1'b0;
    bit           m_first = 1'b1;

    quad_phase_seq #(.WORD_W(W), .NOP_WORD(NOP)) dut_i (
        .clk(clk), .rst_n(rst_n), .fetch_word(fetch_word),
        .pc_change_req(pc_change_req), .phase_oh(phase_oh),
        .pc_adv(pc_adv), .fetch_latch(fetch_latch), .ir_load(ir_load),
        .opnd_rd(opnd_rd), .dst_wr(dst_wr), .flush(flush), .ir_word(ir_word)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(bit ok, string rq, string what, logic [31:0] act, logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", rq, what, act, expv, $time);
        end
    endtask

    // One instruction cycle: word on the fetch bus, request mask per phase.
    task automatic do_cycle(logic [W-1:0] word, logic [3:0] req_mask, bit req_in_flush);
        bit nxt_flush;
        nxt_flush = req_mask[3] && !m_flush;
        for (int k = 0; k < 4; k++) begin
            exp_t e;
            fetch_word    = word;
            pc_change_req = req_mask[k];
            if (k == 1) m_ir = m_flush ? NOP : m_pre;
            e.ph  = 4'b0001 << k;
            e.adv = (k == 0);
            e.lat = (k == 3);
            e.rd  = (k == 1) && !m_flush;
            e.wr  = (k == 3) && !m_flush && !m_first;
            e.fl  = m_flush;
            e.ir  = m_ir;
            e.rd_tag = m_flush ? "R8" : "R5";
            e.wr_tag = m_flush ? "R8" : (m_first ? "R6" : "R5");
            e.fl_tag = req_in_flush ? "R9" : "R7";
            e.ir_tag = m_flush ? "R8" : ((k == 0) ? "R4" : "R10");
            exp_q.push_back(e);
            @(posedge clk); #1;
        end
        m_pre   = word;
        m_flush = nxt_flush;
        m_first = 1'b0;
    endtask

    // Monitor: pop one expected item per clock and compare.
    always @(negedge clk) begin
        if (mon_on && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            chk(phase_oh == e.ph, "R1", "phase_oh", 32'(phase_oh), 32'(e.ph));
            chk(pc_adv == e.adv && ir_load == e.adv, "R3", "pc_adv/ir_load",
                {30'd0, pc_adv, ir_load}, {30'd0, e.adv, e.adv});
            chk(fetch_latch == e.lat, "R4", "fetch_latch", 32'(fetch_latch), 32'(e.lat));
            chk(opnd_rd == e.rd, e.rd_tag, "opnd_rd", 32'(opnd_rd), 32'(e.rd));
            chk(dst_wr == e.wr, e.wr_tag, "dst_wr", 32'(dst_wr), 32'(e.wr));
            chk(flush == e.fl, e.fl_tag, "flush", 32'(flush), 32'(e.fl));
            chk(ir_word == e.ir, e.ir_tag, "ir_word", 32'(ir_word), 32'(e.ir));
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R2 reset state
        chk(phase_oh == 4'b0001, "R2", "phase_oh", 32'(phase_oh), 32'h1);
        chk(flush == 1'b0 && dst_wr == 1'b0, "R2", "flush/dst_wr",
            {30'd0, flush, dst_wr}, 32'h0);
        chk(ir_word == NOP, "R2", "ir_word", 32'(ir_word), 32'(NOP));
        @(posedge clk); #1;
        rst_n  = 1'b1;
        mon_on = 1'b1;
        // R6 first cycle, then R10 sequential stream
        do_cycle(16'h1111, 4'b0000, 0);
        do_cycle(16'h2222, 4'b0000, 0);
        do_cycle(16'h3333, 4'b0000, 0);
        do_cycle(16'h4444, 4'b0000, 0);
        // R7 redirect in phase four
        do_cycle(16'h5555, 4'b1000, 0);
        do_cycle(16'h6666, 4'b0000, 0);
        do_cycle(16'h7777, 4'b0000, 0);
        // R7 request in other phases only: ignored
        do_cycle(16'h8888, 4'b0111, 0);
        do_cycle(16'h9999, 4'b0000, 0);
        // R9 request held through the flushed cycle
        do_cycle(16'hAAAA, 4'b1000, 0);
        do_cycle(16'hBBBB, 4'b1111, 0);
        do_cycle(16'hCCCC, 4'b0000, 1);
        // two redirects one normal cycle apart
        do_cycle(16'hDDDD, 4'b1000, 0);
        do_cycle(16'hEEEE, 4'b0000, 0);
        do_cycle(16'h0F0F, 4'b1000, 0);
        do_cycle(16'hF0F0, 4'b0000, 0);
        do_cycle(16'h1234, 4'b0000, 0);
        do_cycle(16'h5678, 4'b0000, 0);
        @(negedge clk);
        mon_on = 1'b0;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule